// File: doc/BRIEF.md
# Multi-Latency Issue Hazard Gate

This block sits at the decode stage of an in-order pipeline whose execution units take different fixed numbers of cycles: an integer unit, a floating-point adder, a floating-point multiplier and a divider that accepts only one operation at a time. In every cycle it looks at the decoded instruction and either lets it go (`issue`) or holds it (`stall`). Because a short operation issued after a long one can finish first, it guards the single register-file write port and the order of writes to the same register. It also does the usual read-after-write check, which assumes full bypassing.

The block keeps three pieces of state. The first is a shift vector with one bit for each future cycle, which marks when the shared result path (memory stage, then register write) is claimed. The second is a per-register count of the cycles left until a pending write lands. The third is an occupancy flag for the divider, which the divider clears with a completion pulse. A parameter can instead let the flag time out after the divide latency. Operand muxes, the units themselves and exception ordering belong to the neighbouring logic.

Top module: `issue_hazard_gate`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every path reservation, the divider flag and all pending writes. With `dec_valid` low, `issue` and `stall` are both low. The first valid instruction after reset issues.
- R2: A divide (`dec_unit` = 3, `dec_store` low) is held from the cycle after an earlier divide issues up to and including the cycle in which `div_done` is high. It may issue in the next cycle. Instructions for other units are not held by the divider.
- R3: A register writer (`dec_dst_en` high, `dec_store` low) has latency L: 1, 4, 7 or 24 for unit codes 0, 1, 2 and 3. It is held if an instruction that has already issued has claimed the result path for the cycle L cycles ahead.
- R4: A store (`dec_store` high) claims the result path `STORE_OFS` cycles ahead (default 1) and is held if that cycle is already claimed. It writes no register: `dec_dst_en`/`dec_dst` create no pending write, and `dec_unit` is ignored.
- R5: An enabled source register whose pending write lands after the current cycle holds the instruction. The instruction may issue in the landing cycle, by forwarding, so a consumer of a latency-L result issues L cycles after its producer.
- R6: A writer is held while an older write to the same destination would land in the same cycle as its own write or later.
- R7: A write to a register that an older in-flight instruction reads is never held, because operands are read only at decode.
- R8: With `dec_valid` high, exactly one of `issue` and `stall` is high, whatever number of hazards applies. A held instruction claims nothing and records no pending write. Issue happens in the first cycle in which every check passes.
- R9: A source whose enable is low, or a destination whose enable is low, takes no part in any check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_unit | input | 2 | Unit code: 0 integer, 1 FP add, 2 FP multiply, 3 divide |
| dec_store | input | 1 | Instruction is a store |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_dst | input | $clog2(NREGS) | Destination register |
| dec_src1_en | input | 1 | First source is used |
| dec_src1 | input | $clog2(NREGS) | First source register |
| dec_src2_en | input | 1 | Second source is used |
| dec_src2 | input | $clog2(NREGS) | Second source register |
| div_done | input | 1 | Divider finishes its operation this cycle |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode this cycle |

## Verification
All the block's state shows only as an `issue` that should be a `stall`, or the reverse. A fault therefore stays hidden until an instruction probes the affected entry. A stuck or misplaced path-claim bit appears only when a later writer or store lands on exactly that offset, which can be up to 24 cycles after the claim was made. A wrong pending count on a register shows once that register is read or rewritten, as a dependent that issues one cycle early or late. Every cycle of the bench is therefore compared against a model kept in absolute cycle numbers, and the directed sequences are placed so that each hazard is probed at both edges of its window.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

   typedef enum logic [1:0] {
      UNIT_INT  = 2'd0,
      UNIT_FADD = 2'd1,
      UNIT_FMUL = 2'd2,
      UNIT_DIV  = 2'd3
   } unit_e;

   typedef struct packed {
      logic div_busy;
      logic port_taken;
      logic raw_wait;
      logic waw_order;
   } hazard_t;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/ihc_slot_ring.sv
// One bit per future cycle; bit k means "the result path is taken k cycles from now".
module ihc_slot_ring #(
   parameter int DEPTH = 24,
   localparam int OW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [OW-1:0] probe_ofs,
   output logic          probe_busy,
   input  logic          claim,
   input  logic [OW-1:0] claim_ofs
);

   logic [DEPTH:1] taken_q;

   for (genvar i = 1; i <= DEPTH; i++) begin : g_bit
      logic from_above;
      if (i < DEPTH) begin : g_mid
         assign from_above = taken_q[i+1];
      end else begin : g_top
         assign from_above = 1'b0;
      end
      // a claim at offset i+1 becomes offset i after this edge
      always_ff @(posedge clk) begin
         if (rst) taken_q[i] <= 1'b0;
         else     taken_q[i] <= from_above | (claim && (int'(claim_ofs) == i + 1));
      end
   end

   always_comb begin
      probe_busy = 1'b0;
      for (int k = 1; k <= DEPTH; k++) begin
         if (int'(probe_ofs) == k) probe_busy = taken_q[k];
      end
   end

endmodule

// File: rtl/ihc_pend_table.sv
// Per-register count of cycles until the pending write lands (0 = none).
module ihc_pend_table #(
   parameter int NREGS = 32,
   parameter int CW    = 5,
   localparam int RW = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [RW-1:0] look_a,
   input  logic [RW-1:0] look_b,
   input  logic [RW-1:0] look_c,
   output logic [CW-1:0] left_a,
   output logic [CW-1:0] left_b,
   output logic [CW-1:0] left_c,
   input  logic          set_en,
   input  logic [RW-1:0] set_reg,
   input  logic [CW-1:0] set_val
);

   logic [CW-1:0] left_q [NREGS];

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)                                 left_q[r] <= '0;
         else if (set_en && set_reg == RW'(r))    left_q[r] <= set_val;
         else if (left_q[r] != '0)                left_q[r] <= left_q[r] - CW'(1);
      end
   end

   assign left_a = left_q[look_a];
   assign left_b = left_q[look_b];
   assign left_c = left_q[look_c];

endmodule

// File: rtl/ihc_div_track.sv
// Divider occupancy: released by the completion pulse, or by a local timer.
module ihc_div_track #(
   parameter int LAT      = 24,
   parameter bit USE_DONE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic done,
   output logic busy
);

   if (USE_DONE) begin : g_handshake
      logic held_q;
      always_ff @(posedge clk) begin
         if (rst)        held_q <= 1'b0;
         else if (start) held_q <= 1'b1;
         else if (done)  held_q <= 1'b0;
      end
      assign busy = held_q;
   end else begin : g_timer
      localparam int DW = $clog2(LAT + 1);
      logic [DW-1:0] left_q;
      always_ff @(posedge clk) begin
         if (rst)                  left_q <= '0;
         else if (start)           left_q <= DW'(LAT);
         else if (done)            left_q <= '0;
         else if (left_q != '0)    left_q <= left_q - DW'(1);
      end
      assign busy = (left_q != '0);
   end

endmodule

// File: rtl/issue_hazard_gate.sv
module issue_hazard_gate import ihc_pkg::*; #(
   parameter int NREGS       = 32,
   parameter int LAT_INT     = 1,
   parameter int LAT_FADD    = 4,
   parameter int LAT_FMUL    = 7,
   parameter int LAT_DIV     = 24,
   parameter int STORE_OFS   = 1,
   parameter bit DIV_DONE_HS = 1'b1,
   localparam int RW = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          dec_valid,
   input  logic [1:0]    dec_unit,
   input  logic          dec_store,
   input  logic          dec_dst_en,
   input  logic [RW-1:0] dec_dst,
   input  logic          dec_src1_en,
   input  logic [RW-1:0] dec_src1,
   input  logic          dec_src2_en,
   input  logic [RW-1:0] dec_src2,
   input  logic          div_done,
   output logic          issue,
   output logic          stall
);

   localparam int MAXL = max_of4(LAT_INT, LAT_FADD, LAT_FMUL, LAT_DIV);
   localparam int CW   = $clog2(MAXL + 1);

   if (NREGS < 2 || (1 << RW) != NREGS) begin : g_bad_regs
      $error("issue_hazard_gate: NREGS must be a power of two, at least 2");
   end
   if (LAT_INT < 1 || LAT_FADD < 1 || LAT_FMUL < 1 || LAT_DIV < 1) begin : g_bad_lat
      $error("issue_hazard_gate: every latency must be at least 1");
   end
   if (STORE_OFS < 1 || STORE_OFS > MAXL) begin : g_bad_store
      $error("issue_hazard_gate: STORE_OFS must lie within 1..max latency");
   end

   unit_e         unit;
   logic [CW-1:0] lat;
   logic [CW-1:0] path_ofs;
   logic          is_wr, is_div, claims;
   logic          port_busy, div_busy;
   logic [CW-1:0] left_s1, left_s2, left_d;
   hazard_t       hz;

   assign unit = unit_e'(dec_unit);

   always_comb begin
      lat = CW'(LAT_INT);
      case (unit)
         UNIT_INT:  lat = CW'(LAT_INT);
         UNIT_FADD: lat = CW'(LAT_FADD);
         UNIT_FMUL: lat = CW'(LAT_FMUL);
         UNIT_DIV:  lat = CW'(LAT_DIV);
      endcase
   end

   assign is_wr    = dec_dst_en & ~dec_store;
   assign is_div   = ~dec_store & (unit == UNIT_DIV);
   assign claims   = dec_store | is_wr;
   assign path_ofs = dec_store ? CW'(STORE_OFS) : lat;

   ihc_slot_ring #(.DEPTH(MAXL)) u_slots (
      .clk        (clk),
      .rst        (rst),
      .probe_ofs  (path_ofs),
      .probe_busy (port_busy),
      .claim      (issue & claims),
      .claim_ofs  (path_ofs)
   );

   ihc_pend_table #(.NREGS(NREGS), .CW(CW)) u_pend (
      .clk     (clk),
      .rst     (rst),
      .look_a  (dec_src1),
      .look_b  (dec_src2),
      .look_c  (dec_dst),
      .left_a  (left_s1),
      .left_b  (left_s2),
      .left_c  (left_d),
      .set_en  (issue & is_wr),
      .set_reg (dec_dst),
      .set_val (lat)
   );

   ihc_div_track #(.LAT(LAT_DIV), .USE_DONE(DIV_DONE_HS)) u_div (
      .clk   (clk),
      .rst   (rst),
      .start (issue & is_div),
      .done  (div_done),
      .busy  (div_busy)
   );

   // a count of 1 means the value is produced this cycle and can be forwarded
   assign hz.raw_wait   = (dec_src1_en && left_s1 > CW'(1)) ||
                          (dec_src2_en && left_s2 > CW'(1));
   // older write landing at or after our own landing cycle
   assign hz.waw_order  = is_wr && (left_d > lat);
   assign hz.port_taken = claims && port_busy;
   assign hz.div_busy   = is_div && div_busy;

   assign issue = dec_valid & ~(|hz);
   assign stall = dec_valid &  (|hz);

endmodule

// File: rtl/issue_hazard_gate_chk.sv
module issue_hazard_gate_chk #(
   parameter int NREGS     = 32,
   parameter int LAT_FADD  = 4,
   parameter int LAT_FMUL  = 7,
   parameter int STORE_OFS = 1,
   localparam int RW  = $clog2(NREGS),
   localparam int SAT = LAT_FADD + LAT_FMUL + STORE_OFS + 1,
   localparam int SW  = $clog2(SAT + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          dec_valid,
   input logic [1:0]    dec_unit,
   input logic          dec_store,
   input logic          dec_dst_en,
   input logic [RW-1:0] dec_dst,
   input logic          dec_src1_en,
   input logic [RW-1:0] dec_src1,
   input logic          issue,
   input logic          stall
);

   logic wr, fadd_wr, fmul_wr, div_op;
   logic [SW-1:0] since_fadd, since_fmul;

   assign wr      = dec_dst_en & ~dec_store;
   assign fadd_wr = wr & (dec_unit == 2'd1);
   assign fmul_wr = wr & (dec_unit == 2'd2);
   assign div_op  = ~dec_store & (dec_unit == 2'd3);

   always_ff @(posedge clk) begin
      if (rst)                           since_fadd <= SW'(SAT);
      else if (issue && fadd_wr)         since_fadd <= SW'(1);
      else if (since_fadd != SW'(SAT))   since_fadd <= since_fadd + SW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)                           since_fmul <= SW'(SAT);
      else if (issue && fmul_wr)         since_fmul <= SW'(1);
      else if (since_fmul != SW'(SAT))   since_fmul <= since_fmul + SW'(1);
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      !dec_valid |-> (!issue && !stall));

   p_fresh_issue_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && dec_valid) |-> issue);

   p_div_gap_r2: assert property (@(posedge clk) disable iff (rst)
      (issue && div_op) |=> !(issue && div_op));

   p_port_clash_r3: assert property (@(posedge clk) disable iff (rst)
      ((LAT_FMUL > LAT_FADD) && issue && fadd_wr) |->
         (since_fmul != SW'(LAT_FMUL - LAT_FADD)));

   p_store_clash_r4: assert property (@(posedge clk) disable iff (rst)
      ((LAT_FADD > STORE_OFS) && issue && dec_store) |->
         (since_fadd != SW'(LAT_FADD - STORE_OFS)));

   p_raw_wait_r5: assert property (@(posedge clk) disable iff (rst)
      ((LAT_FADD > 1) && issue && fadd_wr) |=>
         !(issue && dec_src1_en && dec_src1 == $past(dec_dst)));

   p_waw_order_r6: assert property (@(posedge clk) disable iff (rst)
      ((LAT_FMUL > LAT_FADD) && issue && fmul_wr) |=>
         !(issue && fadd_wr && dec_dst == $past(dec_dst)));

   p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
      dec_valid |-> (issue ^ stall));

endmodule

bind issue_hazard_gate issue_hazard_gate_chk #(
   .NREGS(NREGS), .LAT_FADD(LAT_FADD), .LAT_FMUL(LAT_FMUL), .STORE_OFS(STORE_OFS)
) u_chk (
   .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_unit(dec_unit),
   .dec_store(dec_store), .dec_dst_en(dec_dst_en), .dec_dst(dec_dst),
   .dec_src1_en(dec_src1_en), .dec_src1(dec_src1), .issue(issue), .stall(stall)
);

// File: tb/issue_hazard_gate_test.sv
module issue_hazard_gate_test;

   localparam int NREGS = 32;
   localparam int RW    = 5;
   localparam int L_INT = 1, L_FADD = 4, L_FMUL = 7, L_DIV = 24, S_OFS = 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dec_valid = 1'b0, dec_store = 1'b0, dec_dst_en = 1'b0;
   logic dec_src1_en = 1'b0, dec_src2_en = 1'b0, div_done = 1'b0;
   logic [1:0] dec_unit = '0;
   logic [RW-1:0] dec_dst = '0, dec_src1 = '0, dec_src2 = '0;
   logic issue, stall;

   int n_checks = 0, n_fail = 0, cyc = 0;
   int land [NREGS];
   int taken [$];
   bit dbusy = 1'b0;
   int done_at = -1;

   always #2 clk = ~clk;

   issue_hazard_gate uut (
      .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_unit(dec_unit),
      .dec_store(dec_store), .dec_dst_en(dec_dst_en), .dec_dst(dec_dst),
      .dec_src1_en(dec_src1_en), .dec_src1(dec_src1),
      .dec_src2_en(dec_src2_en), .dec_src2(dec_src2),
      .div_done(div_done), .issue(issue), .stall(stall)
   );

   function automatic int lat_of(input int u);
      case (u)
         0: return L_INT;
         1: return L_FADD;
         2: return L_FMUL;
         default: return L_DIV;
      endcase
   endfunction

   function automatic bit is_taken(input int c);
      foreach (taken[i]) if (taken[i] == c) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
      end
   endtask

   task automatic step(input bit v, input int u, input bit st, input bit de, input int d,
                       input bit e1, input int s1, input bit e2, input int s2,
                       input string tag, output bit went);
      int  l, ofs;
      bit  hz;
      @(negedge clk);
      cyc++;
      dec_valid = v; dec_unit = u[1:0]; dec_store = st; dec_dst_en = de; dec_dst = d[RW-1:0];
      dec_src1_en = e1; dec_src1 = s1[RW-1:0]; dec_src2_en = e2; dec_src2 = s2[RW-1:0];
      div_done = (cyc == done_at);
      l   = lat_of(u);
      ofs = st ? S_OFS : l;
      hz  = 1'b0;
      if (!st && u == 3 && dbusy)           hz = 1'b1;
      if ((st || de) && is_taken(cyc + ofs)) hz = 1'b1;
      if (e1 && land[s1] > cyc)              hz = 1'b1;
      if (e2 && land[s2] > cyc)              hz = 1'b1;
      if (!st && de && land[d] >= cyc + l)   hz = 1'b1;
      went = v && !hz;
      #1;
      check_bit(tag, "issue", issue, went);
      check_bit(tag, "stall", stall, v && hz);
      if (div_done) dbusy = 1'b0;
      if (went) begin
         if (st || de) taken.push_back(cyc + ofs);
         if (!st && de) land[d] = cyc + l;
         if (!st && u == 3) begin dbusy = 1'b1; done_at = cyc + L_DIV; end
      end
      for (int i = taken.size() - 1; i >= 0; i--) if (taken[i] <= cyc) taken.delete(i);
   endtask

   task automatic idle(input string tag);
      bit w;
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag, w);
   endtask

   // repeat the same instruction until the model says it issues
   task automatic push(input int u, input bit st, input bit de, input int d,
                       input bit e1, input int s1, input bit e2, input int s2, input string tag);
      bit w;
      for (int k = 0; k < 40; k++) begin
         step(1, u, st, de, d, e1, s1, e2, s2, tag, w);
         if (w) break;
      end
   endtask

   task automatic do_reset;
      rst = 1'b1;
      for (int i = 0; i < 3; i++) idle("R1");
      for (int r = 0; r < NREGS; r++) land[r] = -1000;
      taken.delete();
      dbusy = 1'b0;
      done_at = -1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      bit w;
      do_reset();
      idle("R1"); idle("R1");
      push(0, 0, 1, 1, 0, 0, 0, 0, "R1");          // first op after reset issues
      push(0, 0, 1, 2, 1, 1, 0, 0, "R5");          // int -> int forwards back to back
      push(1, 0, 1, 3, 0, 0, 0, 0, "R5");
      push(0, 0, 1, 4, 1, 3, 0, 0, "R5");          // waits for fadd result
      push(2, 0, 1, 5, 0, 0, 0, 0, "R6");
      push(1, 0, 1, 5, 0, 0, 0, 0, "R6");          // would overtake the fmul
      push(2, 0, 1, 6, 0, 0, 0, 0, "R3");
      push(0, 0, 1, 7, 0, 0, 0, 0, "R3");
      push(0, 0, 1, 7, 0, 0, 0, 0, "R3");
      push(1, 0, 1, 8, 0, 0, 0, 0, "R3");          // same landing cycle as fmul
      push(1, 0, 1, 9, 0, 0, 0, 0, "R4");
      push(0, 0, 0, 0, 0, 0, 0, 0, "R4");
      push(0, 0, 0, 0, 0, 0, 0, 0, "R4");
      push(3, 1, 1, 10, 1, 11, 0, 0, "R4");        // store meets fadd in memory stage
      push(0, 0, 1, 12, 1, 10, 0, 0, "R4");        // store left no pending write
      push(3, 0, 1, 13, 0, 0, 0, 0, "R2");
      push(1, 0, 1, 14, 0, 0, 0, 0, "R2");         // other unit unaffected
      push(3, 0, 1, 15, 0, 0, 0, 0, "R2");         // waits for div_done
      push(2, 0, 1, 16, 1, 17, 0, 0, "R7");
      push(0, 0, 1, 17, 0, 0, 0, 0, "R7");         // no write-after-read hold
      push(1, 0, 1, 18, 0, 0, 0, 0, "R9");
      push(0, 0, 0, 18, 0, 18, 0, 18, "R9");       // disabled fields ignored
      push(2, 0, 1, 19, 0, 0, 0, 0, "R8");
      step(1, 1, 0, 1, 20, 1, 19, 0, 0, "R8", w);  // held by RAW
      step(1, 1, 0, 1, 20, 1, 19, 0, 0, "R8", w);
      idle("R8");
      push(0, 0, 1, 21, 1, 20, 0, 0, "R8");        // held op left no pending write
      push(3, 0, 1, 22, 0, 0, 0, 0, "R8");
      push(3, 0, 1, 23, 1, 22, 0, 1, "R8");        // two hazards, one stall
      push(2, 0, 1, 24, 0, 0, 0, 0, "R1");
      push(3, 0, 1, 25, 0, 0, 0, 0, "R1");
      do_reset();
      push(3, 0, 1, 26, 1, 24, 1, 25, "R1");       // state cleared by reset
      for (int i = 0; i < 400; i++) begin
         step(($urandom % 4) != 0, int'($urandom % 4), ($urandom % 8) == 0, ($urandom % 5) != 0,
              int'($urandom % 8), $urandom % 2, int'($urandom % 8), $urandom % 2, int'($urandom % 8),
              "R8", w);
      end
      idle("R1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule